// File: doc/BRIEF.md
# Flash Write-Status Toggle-Bit Generator

This block produces the status word that a parallel NOR-style flash places on its 16-bit read bus while an embedded program or erase is in progress. It follows the operating mode, the sector that is being erased or has been suspended, and the value of bit 7 being programmed. On each host read it returns either the array word unchanged or a status word in which bits 7, 6 and 2 are replaced by polling information.

Two independent one-bit toggles carry the polling information. The bit 6 toggle flips on every read while the device is busy. The bit 2 toggle flips only on reads that land in the tracked sector while that sector is being erased or is suspended. Bit 7 carries a value that depends on the mode. A command decoder outside this block pulses `op_start_i` to begin a new mode. An operation timer outside this block pulses `op_done_i` when the operation finishes. The array storage, command decoding and analog timing are outside this block.

Top module: `flash_status_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `rd_valid_o` is 0. After reset the mode is idle and both toggles are 0.
- R2: In idle mode, a read (`rd_i`=1 at a clock edge) makes `rd_valid_o`=1 on the next cycle, with `rd_data_o` equal to the `arr_data_i` sampled with the read.
- R3: `op_start_i` loads the mode from `op_mode_i` (0 idle, 1 program, 2 erase, 3 erase-suspended, 4 program-in-suspend; values 5 to 7 load idle) and clears both toggles. The first status read after a start returns 0 on bit 6.
- R4: In program, erase and program-in-suspend modes, every read inverts the bit 6 toggle, so back-to-back reads return alternating bit 6 values.
- R5: In program mode, bit 7 returns the complement of the `op_d7_i` captured at the start. Bit 2 returns the bit 2 toggle, which does not change.
- R6: In erase mode, bit 7 returns 0 and bit 2 returns the bit 2 toggle. That toggle inverts only on reads whose address bits [19:11] equal the sector captured at the start. It holds on all other reads.
- R7: In erase-suspended mode, a read inside the tracked sector returns 1 on bits 7 and 6, returns the bit 2 toggle on bit 2, and inverts that toggle. A read outside the tracked sector returns the array word on every bit.
- R8: In program-in-suspend mode, bit 7 returns the complement of the captured `op_d7_i` and bit 6 returns the toggle. Bit 2 returns array bit 2. The sector captured when suspend was entered is kept.
- R9: `op_done_i` returns program and erase to idle and returns program-in-suspend to erase-suspended. It has no effect in idle or erase-suspended mode. When `op_start_i` and `op_done_i` arrive in the same cycle, the start wins.
- R10: In every status word, the bits other than 7, 6 and 2 carry the array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start_i | input | 1 | Pulse: begin a new mode |
| op_mode_i | input | 3 | Mode loaded on start |
| op_sector_i | input | 9 | Sector captured on an erase or suspend start |
| op_d7_i | input | 1 | Bit 7 of the word being programmed |
| op_done_i | input | 1 | Pulse from the operation timer |
| rd_i | input | 1 | Host read strobe |
| rd_addr_i | input | 20 | Read word address |
| arr_data_i | input | 16 | Array word at the read address |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 16 | Array word or status word |

## Verification
The read path is exercised with isolated reads and with back-to-back reads. Back-to-back reads separate a bit 6 that inverts on every read from one that holds. In erase and suspend modes, reads alternate between addresses inside and outside the tracked sector, which shows that the bit 2 toggle moves only on in-sector reads. Array words with many bits set or alternating bit patterns show which bits are replaced and which pass through. Done pulses, a start and a done in the same cycle, and an out-of-range mode code confirm the mode transitions through the read data that follows.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [2:0] {
        FSG_IDLE  = 3'd0,
        FSG_PROG  = 3'd1,
        FSG_ERASE = 3'd2,
        FSG_SUSP  = 3'd3,
        FSG_SPROG = 3'd4
    } fsg_mode_e;
endpackage

// File: rtl/fsg_mode_track.sv
module fsg_mode_track
    import fsg_pkg::*;
#(
    parameter int SECT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        mode_i,
    input  logic [SECT_W-1:0] sector_i,
    input  logic              d7_i,
    input  logic              done_i,
    output fsg_mode_e         mode_o,
    output logic [SECT_W-1:0] sector_o,
    output logic              d7_o
);
    typedef struct packed {
        fsg_mode_e         mode;
        logic [SECT_W-1:0] sector;
        logic              d7;
    } trk_t;

    trk_t trk_d, trk_q;
    fsg_mode_e req_mode;

    always_comb begin
        case (mode_i)
            3'd1:    req_mode = FSG_PROG;
            3'd2:    req_mode = FSG_ERASE;
            3'd3:    req_mode = FSG_SUSP;
            3'd4:    req_mode = FSG_SPROG;
            default: req_mode = FSG_IDLE;
        endcase
    end

    always_comb begin
        trk_d = trk_q;
        if (start_i) begin
            trk_d.mode = req_mode;
            if (req_mode == FSG_ERASE || req_mode == FSG_SUSP)
                trk_d.sector = sector_i;
            if (req_mode == FSG_PROG || req_mode == FSG_SPROG)
                trk_d.d7 = d7_i;
        end else if (done_i) begin
            case (trk_q.mode)
                FSG_PROG, FSG_ERASE: trk_d.mode = FSG_IDLE;
                FSG_SPROG:           trk_d.mode = FSG_SUSP;
                default:             trk_d.mode = trk_q.mode;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '{mode: FSG_IDLE, sector: '0, d7: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign mode_o   = trk_q.mode;
    assign sector_o = trk_q.sector;
    assign d7_o     = trk_q.d7;

    // R9: a finished program-in-suspend falls back to the suspended erase
    a_r9_sprog_done_to_susp: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.mode == FSG_SPROG && done_i && !start_i) |=> (trk_q.mode == FSG_SUSP));
    // R9: program and erase end in idle
    a_r9_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((trk_q.mode == FSG_PROG || trk_q.mode == FSG_ERASE) && done_i && !start_i)
        |=> (trk_q.mode == FSG_IDLE));
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic flip_i,
    output logic q_o
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (clr_i)       tog_d = 1'b0;
        else if (flip_i) tog_d = ~tog_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    assign q_o = tog_q;

    // R3: a new operation starts the toggle from 0
    a_r3_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);
    // R4: a counted read inverts the toggle
    a_r4_flip_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_i && !clr_i) |=> (q_o != $past(q_o)));
endmodule

// File: rtl/fsg_sector_hit.sv
module fsg_sector_hit #(
    parameter int ADDR_W   = 20,
    parameter int SECT_LSB = 11,
    localparam int SECT_W  = ADDR_W - SECT_LSB
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SECT_W-1:0] sector_i,
    output logic              hit_o
);
    assign hit_o = (addr_i[ADDR_W-1:SECT_LSB] == sector_i);
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int SECT_LSB = 11,
    parameter int DATA_W   = 16,
    localparam int SECT_W  = ADDR_W - SECT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start_i,
    input  logic [2:0]        op_mode_i,
    input  logic [SECT_W-1:0] op_sector_i,
    input  logic              op_d7_i,
    input  logic              op_done_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DATA_W-1:0] arr_data_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int NUM_TOG = 2;
    localparam int T_DQ6   = 0;
    localparam int T_DQ2   = 1;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    fsg_mode_e         mode_w;
    logic [SECT_W-1:0] sector_w;
    logic              d7_w;
    logic              hit_w;
    logic [NUM_TOG-1:0] tog_q, tog_flip;
    logic [DATA_W-1:0] status;
    rd_t               rd_d, rd_q;

    fsg_mode_track #(.SECT_W(SECT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (op_start_i),
        .mode_i   (op_mode_i),
        .sector_i (op_sector_i),
        .d7_i     (op_d7_i),
        .done_i   (op_done_i),
        .mode_o   (mode_w),
        .sector_o (sector_w),
        .d7_o     (d7_w)
    );

    fsg_sector_hit #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_hit (
        .addr_i   (rd_addr_i),
        .sector_i (sector_w),
        .hit_o    (hit_w)
    );

    for (genvar g = 0; g < NUM_TOG; g++) begin : g_tog
        fsg_toggle u_tog (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (op_start_i),
            .flip_i (tog_flip[g]),
            .q_o    (tog_q[g])
        );
    end

    always_comb begin
        status   = arr_data_i;
        tog_flip = '0;
        case (mode_w)
            FSG_PROG: begin
                status[7] = ~d7_w;
                status[6] = tog_q[T_DQ6];
                status[2] = tog_q[T_DQ2];
                tog_flip[T_DQ6] = rd_i;
            end
            FSG_ERASE: begin
                status[7] = 1'b0;
                status[6] = tog_q[T_DQ6];
                status[2] = tog_q[T_DQ2];
                tog_flip[T_DQ6] = rd_i;
                tog_flip[T_DQ2] = rd_i && hit_w;
            end
            FSG_SUSP: begin
                if (hit_w) begin
                    status[7] = 1'b1;
                    status[6] = 1'b1;
                    status[2] = tog_q[T_DQ2];
                    tog_flip[T_DQ2] = rd_i;
                end
            end
            FSG_SPROG: begin
                status[7] = ~d7_w;
                status[6] = tog_q[T_DQ6];
                tog_flip[T_DQ6] = rd_i;
            end
            default: status = arr_data_i;
        endcase
    end

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_i;
        if (rd_i) rd_d.data = status;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid_o = rd_q.valid;
    assign rd_data_o  = rd_q.data;

    // R2: idle reads return the array word one cycle later
    a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && mode_w == FSG_IDLE) |=> (rd_valid_o && rd_data_o == $past(arr_data_i)));
    // R6: erase reports bit 7 low
    a_r6_erase_dq7_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && mode_w == FSG_ERASE) |=> (rd_valid_o && !rd_data_o[7]));
    // R7: suspended sector reads report bits 7 and 6 high
    a_r7_susp_hit_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && mode_w == FSG_SUSP && hit_w) |=> (rd_data_o[7] && rd_data_o[6]));
    // R1: no result without a read
    a_r1_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rd_valid_o);
endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start_i = 1'b0;
    logic [2:0]  op_mode_i = '0;
    logic [8:0]  op_sector_i = '0;
    logic        op_d7_i = 1'b0;
    logic        op_done_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [19:0] rd_addr_i = '0;
    logic [15:0] arr_data_i = '0;
    logic        rd_valid_o;
    logic [15:0] rd_data_o;

    always #2 clk = ~clk;

    flash_status_gen dut (.*);

    logic [15:0] exp_q[$];
    string       tag_q[$];
    int drv_run = 0, drv_fail = 0, mon_run = 0, mon_fail = 0;
    int cyc = 0;

    // reference model state
    int   m_mode = 0;
    logic m_t6 = 0, m_t2 = 0, m_d7 = 0;
    logic [8:0] m_sect = '0;

    always @(negedge clk) begin
        if (rd_valid_o) begin
            mon_run++;
            if (exp_q.size() == 0) begin
                mon_fail++;
                $display("FAIL unexpected result got %h expected none", rd_data_o);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data_o !== e) begin
                    mon_fail++;
                    $display("FAIL %s got %h expected %h", t, rd_data_o, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            $display("FAIL watchdog got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed",
                     drv_run + mon_run + 1, drv_fail + mon_fail + 1);
            $finish;
        end
    end

    task automatic rd(input logic [19:0] a, input logic [15:0] arr, input string tag);
        logic [15:0] e;
        logic hit;
        e = arr;
        hit = (a[19:11] == m_sect);
        case (m_mode)
            1: begin e[7] = ~m_d7; e[6] = m_t6; e[2] = m_t2; m_t6 = ~m_t6; end
            2: begin e[7] = 1'b0; e[6] = m_t6; e[2] = m_t2; m_t6 = ~m_t6;
                     if (hit) m_t2 = ~m_t2; end
            3: if (hit) begin e[7] = 1'b1; e[6] = 1'b1; e[2] = m_t2; m_t2 = ~m_t2; end
            4: begin e[7] = ~m_d7; e[6] = m_t6; m_t6 = ~m_t6; end
            default: e = arr;
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_i = 1'b1; rd_addr_i = a; arr_data_i = arr;
        @(posedge clk); #1;
        rd_i = 1'b0;
    endtask

    task automatic start(input logic [2:0] m, input logic [8:0] s, input logic d7,
                         input logic with_done);
        op_start_i = 1'b1; op_mode_i = m; op_sector_i = s; op_d7_i = d7;
        op_done_i = with_done;
        m_mode = (m > 3'd4) ? 0 : int'(m);
        if (m == 3'd2 || m == 3'd3) m_sect = s;
        if (m == 3'd1 || m == 3'd4) m_d7 = d7;
        m_t6 = 1'b0; m_t2 = 1'b0;
        @(posedge clk); #1;
        op_start_i = 1'b0; op_done_i = 1'b0;
    endtask

    task automatic done();
        op_done_i = 1'b1;
        if (m_mode == 1 || m_mode == 2) m_mode = 0;
        else if (m_mode == 4) m_mode = 3;
        @(posedge clk); #1;
        op_done_i = 1'b0;
    endtask

    localparam logic [19:0] IN5  = 20'h02800;
    localparam logic [19:0] OUT6 = 20'h03010;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        drv_run++;
        if (rd_valid_o !== 1'b0) begin
            drv_fail++;
            $display("FAIL R1 reset valid got %b expected 0", rd_valid_o);
        end
        rst_n = 1'b1;
        @(posedge clk); #1;
        drv_run++;
        if (rd_valid_o !== 1'b0) begin
            drv_fail++;
            $display("FAIL R1 post-reset valid got %b expected 0", rd_valid_o);
        end
        rd(20'h00010, 16'hA5C3, "R2 idle read");
        rd(20'h00011, 16'hFFFF, "R2 idle read all ones");
        // program, back-to-back reads
        start(3'd1, 9'd0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) rd(20'h00100 + 20'(i), 16'hFFFF, "R3 R4 R5 R10 program");
        rd(20'h00200, 16'h5555, "R10 program pattern");
        done();
        rd(20'h00200, 16'h1234, "R9 program done idle");
        // erase, mixed sectors
        start(3'd2, 9'd5, 1'b0, 1'b0);
        rd(IN5,  16'hFFFF, "R6 erase in-sector");
        rd(OUT6, 16'hFFFF, "R6 erase out-sector holds dq2");
        rd(OUT6, 16'h0000, "R6 erase out-sector");
        rd(IN5,  16'hAAAA, "R6 erase in-sector");
        rd(IN5,  16'hFFFF, "R4 R6 erase back-to-back");
        // suspend
        start(3'd3, 9'd5, 1'b0, 1'b0);
        rd(IN5,  16'h0000, "R7 suspend in-sector");
        rd(OUT6, 16'hBEEF, "R7 suspend out-sector array");
        rd(IN5,  16'h0000, "R7 suspend in-sector dq2");
        done();
        rd(IN5,  16'h0000, "R9 done ignored in suspend");
        // program during suspend
        start(3'd4, 9'd0, 1'b0, 1'b0);
        rd(OUT6, 16'h0004, "R8 suspend program");
        rd(OUT6, 16'h0000, "R8 suspend program toggle");
        rd(IN5,  16'hFFFB, "R8 suspend program dq2 array");
        done();
        rd(IN5,  16'h0000, "R9 back to suspend");
        rd(OUT6, 16'hC0DE, "R9 back to suspend out-sector");
        // start wins over done
        start(3'd1, 9'd0, 1'b0, 1'b1);
        rd(20'h00300, 16'h0000, "R9 start beats done");
        rd(20'h00300, 16'h0000, "R9 start beats done toggle");
        // out-of-range mode code
        start(3'd7, 9'd0, 1'b0, 1'b0);
        rd(IN5, 16'h7E81, "R3 mode 7 idle");
        done();
        rd(IN5, 16'h0102, "R9 done ignored in idle");
        repeat (4) @(posedge clk);
        #1;
        drv_run++;
        if (exp_q.size() != 0) begin
            drv_fail++;
            $display("FAIL R2 pending results got %0d expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", drv_run + mon_run, drv_fail + mon_fail);
        $finish;
    end
endmodule